// File: doc/BRIEF.md
# Armed Threshold Trigger with Oscillator Phase Capture

This block watches a 14-bit two's-complement sample stream at the full clock rate and fires when the stream crosses a programmable level in a chosen direction. A hysteresis band stops noise from re-firing it. Before a crossing can count as a rising event, the input must first fall below the lower edge of the band. Before a crossing can count as a falling event, the input must first rise above the upper edge of the band.

Each firing does three things. It drops the armed flag unless automatic rearming is on. It copies a free-running cycle counter into a timestamp register. It latches the current phase word of a reference oscillator. The block's single signed output can show either a one-cycle full-scale pulse or the latched phase. The latched phase has a signed offset added to it and can be folded to its magnitude. Phase maps to output codes as follows: code 0 is zero phase, the most negative code is half a turn, and the most positive code is just short of half a turn.

Top module: `phase_trigger`

## Requirements
- R1: While reset is asserted and right after it is released, `armed`, `fire`, `timestamp` and `trig_out` are all zero.
- R2: A one-cycle `arm_set` pulse moves the block from state IDLE to state ARMED, and `armed` is 1 in the next cycle. A crossing seen in IDLE produces no `fire` and leaves `trig_out` unchanged.
- R3: With `edge_mode` = 1 (rising), the block fires when a sample is at or above `threshold`, provided an earlier sample was below `threshold - hysteresis` and no rising event has occurred since then. `fire` is high in the cycle after the clock edge that sampled that input.
- R4: With `edge_mode` = 2 (falling), the block fires when a sample is at or below `threshold`, provided an earlier sample was above `threshold + hysteresis` and no falling event has occurred since then.
- R5: With `edge_mode` = 3, both rising and falling events fire. With `edge_mode` = 0, nothing fires and `armed` is unchanged.
- R6: On a firing, the transition ARMED to IDLE is taken, so `armed` reads 0 alongside `fire`, unless `auto_rearm` = 1. In that case the block stays in ARMED.
- R7: A free-running counter starts at 0 after reset and counts every clock edge. On a firing, `timestamp` takes the counter value that applied at the sampling edge. `timestamp` holds between firings.
- R8: On a firing, `phase_in` at the sampling edge is captured and held until the next firing. With `out_sel` = 1, `trig_out` shows that captured phase after the processing in R10 and R11.
- R9: With `out_sel` = 0, `trig_out` is +8191 in each cycle where `fire` is 1, and 0 otherwise.
- R10: `phase_offset` is added to the captured phase modulo 2^14, and this happens before any magnitude folding.
- R11: With `abs_en` = 1, a negative processed phase is replaced by its negation, and -8192 becomes +8191.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_in | input | 14 | Signed input sample |
| threshold | input | 14 | Signed trigger level |
| hysteresis | input | 14 | Unsigned half-width of the hysteresis band |
| edge_mode | input | 2 | 0 off, 1 rising, 2 falling, 3 both |
| arm_set | input | 1 | Pulse that arms the trigger |
| auto_rearm | input | 1 | Stay armed after a firing |
| out_sel | input | 1 | 0 pulse output, 1 phase output |
| phase_in | input | 14 | Top bits of the oscillator phase accumulator, signed |
| phase_offset | input | 14 | Signed offset added to the captured phase |
| abs_en | input | 1 | Fold the processed phase to its magnitude |
| armed | output | 1 | Trigger is armed (state ARMED) |
| fire | output | 1 | One-cycle firing strobe |
| timestamp | output | 32 | Counter value at the last firing |
| trig_out | output | 14 | Signed output: pulse level or processed phase |

## Verification
The case hardest to reach from the ports is a crossing that lands while the block is disarmed. That crossing still uses up the detector's readiness, yet it must leave the output and the timestamp untouched. The stimulus reaches it with `auto_rearm` off: one falling crossing disarms the block, and a full rising excursion follows before `arm_set` is pulsed again. A table of samples walks the band edges, including a return into the band that must not re-fire. The -8192 fold and an offset that wraps past full scale are reached by capturing chosen phase words and then changing the offset and fold controls while the captured value is held.

// File: rtl/phase_trig_pkg.sv
package phase_trig_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_e;

endpackage

// File: rtl/pt_hyst_det.sv
module pt_hyst_det #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    input  logic [W-1:0] thr,
    input  logic [W-1:0] hyst,
    output logic         rise_x,
    output logic         fall_x
);
    localparam int XW = W + 2;

    logic signed [XW-1:0] s_x, t_x, h_x, lo_x, hi_x;
    logic                 rise_rdy_q, fall_rdy_q;

    assign s_x  = {{2{sig[W-1]}}, sig};
    assign t_x  = {{2{thr[W-1]}}, thr};
    assign h_x  = {2'b00, hyst};
    assign lo_x = t_x - h_x;
    assign hi_x = t_x + h_x;

    assign rise_x = rise_rdy_q && (s_x >= t_x);
    assign fall_x = fall_rdy_q && (s_x <= t_x);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_rdy_q <= 1'b0;
            fall_rdy_q <= 1'b0;
        end else begin
            if (s_x < lo_x)  rise_rdy_q <= 1'b1;
            else if (rise_x) rise_rdy_q <= 1'b0;
            if (s_x > hi_x)  fall_rdy_q <= 1'b1;
            else if (fall_x) fall_rdy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
    import phase_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] edge_mode,
    input  logic       arm_set,
    input  logic       auto_rearm,
    input  logic       rise_x,
    input  logic       fall_x,
    output logic       armed,
    output logic       hit
);
    arm_state_e state_q, state_d;
    edge_mode_e mode;
    logic       evt;

    assign mode = edge_mode_e'(edge_mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (mode)
            EDGE_OFF:  evt = 1'b0;
            EDGE_RISE: evt = rise_x;
            EDGE_FALL: evt = fall_x;
            EDGE_BOTH: evt = rise_x | fall_x;
        endcase
        armed   = (state_q == ST_ARMED);
        hit     = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_set) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                hit = evt;
                if (evt && !auto_rearm && !arm_set) state_d = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/pt_capture.sv
module pt_capture #(
    parameter int W    = 14,
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit,
    input  logic [W-1:0]    phase_in,
    output logic            fire_q,
    output logic [W-1:0]    cap_q,
    output logic [TS_W-1:0] ts_q
);
    logic [TS_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
            cap_q  <= '0;
            ts_q   <= '0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            fire_q <= hit;
            if (hit) begin
                cap_q <= phase_in;
                ts_q  <= cnt_q;
            end
        end
    end
endmodule

// File: rtl/pt_phase_fold.sv
module pt_phase_fold #(
    parameter int W = 14
) (
    input  logic [W-1:0] cap,
    input  logic [W-1:0] offset,
    input  logic         abs_en,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] sum;

    assign sum = cap + offset;

    always_comb begin
        if (abs_en && sum[W-1]) begin
            if (sum == MOST_NEG) res = MOST_POS;
            else                 res = ~sum + 1'b1;
        end else begin
            res = sum;
        end
    end
endmodule

// File: rtl/phase_trigger.sv
module phase_trigger #(
    parameter int W    = 14,
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    sig_in,
    input  logic [W-1:0]    threshold,
    input  logic [W-1:0]    hysteresis,
    input  logic [1:0]      edge_mode,
    input  logic            arm_set,
    input  logic            auto_rearm,
    input  logic            out_sel,
    input  logic [W-1:0]    phase_in,
    input  logic [W-1:0]    phase_offset,
    input  logic            abs_en,
    output logic            armed,
    output logic            fire,
    output logic [TS_W-1:0] timestamp,
    output logic [W-1:0]    trig_out
);
    localparam logic [W-1:0] FULL_POS = {1'b0, {(W-1){1'b1}}};

    logic         rise_x, fall_x, hit;
    logic [W-1:0] cap, folded;

    pt_hyst_det #(.W(W)) u_det (
        .clk(clk), .rst_n(rst_n), .sig(sig_in), .thr(threshold),
        .hyst(hysteresis), .rise_x(rise_x), .fall_x(fall_x)
    );

    pt_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .arm_set(arm_set),
        .auto_rearm(auto_rearm), .rise_x(rise_x), .fall_x(fall_x),
        .armed(armed), .hit(hit)
    );

    pt_capture #(.W(W), .TS_W(TS_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .hit(hit), .phase_in(phase_in),
        .fire_q(fire), .cap_q(cap), .ts_q(timestamp)
    );

    pt_phase_fold #(.W(W)) u_fold (
        .cap(cap), .offset(phase_offset), .abs_en(abs_en), .res(folded)
    );

    assign trig_out = out_sel ? folded : (fire ? FULL_POS : '0);
endmodule

// File: rtl/phase_trigger_chk.sv
module phase_trigger_chk #(
    parameter int W    = 14,
    parameter int TS_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      edge_mode,
    input logic            arm_set,
    input logic            auto_rearm,
    input logic            out_sel,
    input logic            abs_en,
    input logic            armed,
    input logic            fire,
    input logic [TS_W-1:0] timestamp,
    input logic [W-1:0]    trig_out
);
    localparam logic [W-1:0] FULL_POS = {1'b0, {(W-1){1'b1}}};

    AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(armed)); // R2
    AST_OFF_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ($past(edge_mode) != 2'd0)); // R5
    AST_DISARM_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !$past(auto_rearm) && !$past(arm_set)) |-> !armed); // R6
    AST_STAY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && $past(auto_rearm)) |-> armed); // R6
    AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |-> $stable(timestamp)); // R7
    AST_PULSE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_sel && fire) |-> (trig_out == FULL_POS)); // R9
    AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_sel && !fire) |-> (trig_out == '0)); // R9
    AST_FOLD_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel && abs_en) |-> !trig_out[W-1]); // R11
endmodule

bind phase_trigger phase_trigger_chk #(.W(W), .TS_W(TS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .arm_set(arm_set),
    .auto_rearm(auto_rearm), .out_sel(out_sel), .abs_en(abs_en),
    .armed(armed), .fire(fire), .timestamp(timestamp), .trig_out(trig_out)
);

// File: tb/phase_trigger_bench.sv
`timescale 1ns/1ps
module phase_trigger_bench;
    localparam int W = 14;
    localparam int TS_W = 32;
    localparam int TBL_N = 9;
    // rising mode, threshold 1000, band 200, auto rearm, phase output
    localparam int T_SIG  [TBL_N] = '{0, 1000, 900, 1100, 799, 999, 1500, -8192, 8191};
    localparam int T_PH   [TBL_N] = '{7, 111, 222, 333, 444, 555, -5, 66, 4000};
    localparam int T_FIRE [TBL_N] = '{0, 1, 0, 0, 0, 0, 1, 0, 1};
    localparam int T_OUT  [TBL_N] = '{0, 111, 111, 111, 111, 111, -5, -5, 4000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] sig_in = '0, threshold = '0, hysteresis = '0;
    logic [W-1:0] phase_in = '0, phase_offset = '0;
    logic [1:0] edge_mode = 2'd0;
    logic arm_set = 1'b0, auto_rearm = 1'b0, out_sel = 1'b0, abs_en = 1'b0;
    logic armed, fire;
    logic [TS_W-1:0] timestamp;
    logic [W-1:0] trig_out;

    int n_chk = 0;
    int n_fail = 0;
    longint bcnt;
    longint ts_keep;

    always #2.5 clk = ~clk;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) bcnt <= 0;
        else        bcnt <= bcnt + 1;

    phase_trigger #(.W(W), .TS_W(TS_W)) u_phase_trigger (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .threshold(threshold),
        .hysteresis(hysteresis), .edge_mode(edge_mode), .arm_set(arm_set),
        .auto_rearm(auto_rearm), .out_sel(out_sel), .phase_in(phase_in),
        .phase_offset(phase_offset), .abs_en(abs_en), .armed(armed),
        .fire(fire), .timestamp(timestamp), .trig_out(trig_out)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int s, input int p);
        sig_in   = W'(s);
        phase_in = W'(p);
        @(negedge clk);
    endtask

    task automatic arm_pulse();
        arm_set = 1'b1;
        @(negedge clk);
        arm_set = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 armed", armed, 0);
        check("R1 fire", fire, 0);
        check("R1 out", $signed(trig_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ts", timestamp, 0);
        check("R1 armed after release", armed, 0);

        // table: rising mode with auto rearm, phase output
        threshold = W'(1000); hysteresis = W'(200); edge_mode = 2'd1;
        auto_rearm = 1'b1; out_sel = 1'b1;
        arm_pulse();
        check("R2 armed after pulse", armed, 1);
        for (int i = 0; i < TBL_N; i++) begin
            step(T_SIG[i], T_PH[i]);
            check("R3 fire", fire, T_FIRE[i]);
            check("R8 phase out", $signed(trig_out), T_OUT[i]);
            check("R6 stays armed", armed, 1);
            if (T_FIRE[i] != 0) check("R7 timestamp", timestamp, bcnt - 1);
        end

        // off mode: no firing
        edge_mode = 2'd0;
        step(0, 1); step(2000, 2);
        check("R5 off no fire", fire, 0);
        check("R5 off armed kept", armed, 1);

        // both mode without rearm
        edge_mode = 2'd3; auto_rearm = 1'b0; threshold = '0; hysteresis = W'(100);
        step(2000, 9);
        step(-50, 1234);
        check("R4 falling fire", fire, 1);
        check("R6 disarm", armed, 0);
        check("R8 captured", $signed(trig_out), 1234);
        ts_keep = timestamp;
        step(-500, 10); step(500, 20);
        check("R2 disarmed no fire", fire, 0);
        check("R2 disarmed out kept", $signed(trig_out), 1234);
        check("R7 ts kept", timestamp, ts_keep);
        arm_pulse();
        step(-500, 77);
        check("R5 both falling", fire, 1);
        check("R8 second capture", $signed(trig_out), 77);
        arm_pulse();
        step(300, 88);
        check("R5 both rising", fire, 1);
        check("R6 disarm again", armed, 0);

        // pulse output
        out_sel = 1'b0; auto_rearm = 1'b1; edge_mode = 2'd1;
        arm_pulse();
        step(-500, 0); step(300, 0);
        check("R9 pulse high", $signed(trig_out), 8191);
        step(300, 0);
        check("R9 pulse low", $signed(trig_out), 0);
        check("R9 no fire", fire, 0);

        // offset and fold
        out_sel = 1'b1;
        step(-500, 0); step(300, -8192);
        check("R8 min phase", $signed(trig_out), -8192);
        abs_en = 1'b1; #1;
        check("R11 fold min", $signed(trig_out), 8191);
        phase_offset = W'(50); abs_en = 1'b0; #1;
        check("R10 offset", $signed(trig_out), -8142);
        abs_en = 1'b1; #1;
        check("R11 fold offset", $signed(trig_out), 8142);
        phase_offset = '0; abs_en = 1'b0;
        @(negedge clk);
        step(-500, 0); step(300, 8000);
        phase_offset = W'(500); #1;
        check("R10 wrap", $signed(trig_out), -7884);
        abs_en = 1'b1; #1;
        check("R11 fold wrap", $signed(trig_out), 7884);
        phase_offset = '0;
        @(negedge clk);
        step(-500, 0); step(300, -100);
        phase_offset = W'(-50); #1;
        check("R10 add before fold", $signed(trig_out), 150);

        // timestamp hold
        ts_keep = timestamp;
        repeat (5) step(300, 5);
        check("R7 hold", timestamp, ts_keep);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule